// File: doc/BRIEF.md
# Fan Start-Up and Drive-Fail Sequencer

This block takes a fan driver from standstill to closed-loop operation. A start request opens a spin-up window whose length is measured in ticks of a 1 kHz timebase strobe. During the window the duty output can first be forced to full scale for a quarter of the window, which breaks static friction. It then holds a programmed spin level until the window ends. After that the block enters a closed-loop phase. In that phase the duty output passes through the value supplied by an external RPM controller.

On entry to the closed-loop phase an optional watchdog window opens. The window counts update-period strobes. If the tach-at-target indication never rises before the last strobe of the window, a sticky drive-fail flag is raised. All options come from one 8-bit configuration byte. Software can freeze that byte by setting a lock, which stays set until reset.

Top module: `fan_start_seq`

## Requirements
- R1: After reset the configuration reads 0x0D, the duty output is 0, neither phase output is high and the drive-fail flag is low.
- R2: While the lock is clear, a write strobe stores the write data into the configuration byte on the next clock, and the stored byte is visible on the configuration output.
- R3: Once the lock input has been pulsed, the lock stays set until reset and every later configuration write is ignored.
- R4: When configuration bit 5 is 0, the duty is 0xFF (full scale) for the first spin-up-ticks/4 timebase ticks after a start, and is the spin-level duty after that.
- R5: When configuration bit 5 is 1, the spin-level duty is output for the whole spin-up window, with no full-scale phase.
- R6: The spin level in configuration bits 4:2 (value L) gives a duty of floor((30+5*L)*255/100): 76, 89, 102, 114, 127, 140, 153 and 165 for L = 0 to 7.
- R7: Configuration bits 1:0 select a spin-up window of 250, 500, 1000 or 2000 timebase ticks for codes 0 to 3. When the window ends, the block enters the closed-loop phase and the duty output follows the loop duty input.
- R8: A start request during spin-up or during the closed-loop phase restarts the spin-up window from tick zero, including the full-scale phase.
- R9: A stop request returns the block to idle with a duty of 0. A stop request wins over a simultaneous start request.
- R10: Configuration bits 7:6 select a drive-fail window of 16, 32 or 64 update strobes for codes 1, 2 and 3. The flag sets on the strobe that completes the window, provided tach-at-target stayed low throughout the closed-loop phase.
- R11: Tach-at-target going high during the window ends the window without a failure, and later strobes cannot set the flag.
- R12: The drive-fail flag is sticky through stop and idle, and is cleared by the clear input. When a set and a clear fall in the same cycle, the set wins.
- R13: Code 0 in configuration bits 7:6 disables drive-fail detection, so no number of strobes sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| lockSet | input | 1 | Sets the sticky write lock |
| startReq | input | 1 | Start (or restart) spin-up |
| stopReq | input | 1 | Return to idle |
| msTick | input | 1 | 1 kHz timebase strobe |
| updateStrobe | input | 1 | Closed-loop update-period strobe |
| tachAtTarget | input | 1 | Measured tach has reached target |
| loopDuty | input | 8 | Duty from the closed-loop controller |
| failClear | input | 1 | Clears the drive-fail flag |
| dutyOut | output | 8 | Duty to the PWM generator |
| spinActive | output | 1 | Spin-up phase running |
| monitorActive | output | 1 | Closed-loop phase running |
| driveFail | output | 1 | Sticky drive-fail flag |
| cfgOut | output | 8 | Current configuration byte |

## Verification
The hardest condition to reach is the last strobe of a drive-fail window. The window exists only after a complete spin-up window, and it needs up to 64 update strobes with tach-at-target held low. The stimulus holds the timebase strobe high on every cycle, so a spin-up window lasts exactly as many clocks as it has ticks. It then issues counted single-cycle update pulses and samples the flag one strobe before and on the completing strobe. It also asserts the clear input on that same completing strobe to show that the set takes priority.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SPIN, PH_MON} phase_t;

  typedef struct packed {
    phase_t phase;
    logic   clrSpin;
    logic   incSpin;
    logic   armWin;
    logic   dropWin;
    logic   stepWin;
  } seq_cmd_t;

  typedef struct packed {
    logic spinLast;
  } seq_stat_t;

  localparam logic [7:0] CFG_RESET = 8'h0D;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      stopReq,
  input  logic      msTick,
  input  logic      updateStrobe,
  input  seq_stat_t stat,
  output seq_cmd_t  cmd
);
  phase_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    cmd         = '0;
    cmd.phase   = state;
    unique case (state)
      PH_IDLE: begin
        if (startReq && !stopReq) begin
          nextState   = PH_SPIN;
          cmd.clrSpin = 1'b1;
        end
      end
      PH_SPIN: begin
        if (stopReq) begin
          nextState = PH_IDLE;
        end else if (startReq) begin
          cmd.clrSpin = 1'b1;
        end else if (msTick) begin
          if (stat.spinLast) begin
            nextState  = PH_MON;
            cmd.armWin = 1'b1;
          end else begin
            cmd.incSpin = 1'b1;
          end
        end
      end
      PH_MON: begin
        cmd.stepWin = updateStrobe;
        if (stopReq) begin
          nextState   = PH_IDLE;
          cmd.dropWin = 1'b1;
        end else if (startReq) begin
          nextState   = PH_SPIN;
          cmd.clrSpin = 1'b1;
          cmd.dropWin = 1'b1;
        end
      end
      default: nextState = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
#(
  parameter int TICK_BASE = 250,
  parameter int WIN_BASE  = 16,
  parameter int DUTY_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_cmd_t          cmd,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic              lockSet,
  input  logic              tachAtTarget,
  input  logic [DUTY_W-1:0] loopDuty,
  input  logic              failClear,
  output seq_stat_t         stat,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              driveFail,
  output logic [7:0]        cfgOut
);
  localparam int SPIN_MAX = TICK_BASE * 8;
  localparam int SPIN_W   = $clog2(SPIN_MAX);
  localparam int WIN_MAX  = WIN_BASE * 4;
  localparam int WIN_W    = $clog2(WIN_MAX + 1);
  localparam int FULL     = (1 << DUTY_W) - 1;
  localparam int LEVELS   = 8;

  logic [7:0]        cfgReg;
  logic              locked;
  logic [SPIN_W-1:0] spinCnt;
  logic [SPIN_W-1:0] spinTicks;
  logic [SPIN_W-1:0] kickTicks;
  logic [WIN_W-1:0]  winCnt;
  logic [WIN_W-1:0]  winLen;
  logic              winArmed;
  logic              winLast;
  logic              failSet;
  logic [DUTY_W-1:0] levelTab [LEVELS];

  wire [1:0] failCode = cfgReg[7:6];
  wire       noKick   = cfgReg[5];
  wire [2:0] spinLvl  = cfgReg[4:2];
  wire [1:0] timeCode = cfgReg[1:0];

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    assign levelTab[g] = DUTY_W'(((30 + 5 * g) * FULL) / 100);
  end

  // configuration byte and lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RESET;
      locked <= 1'b0;
    end else begin
      if (lockSet) locked <= 1'b1;
      if (cfgWrEn && !locked) cfgReg <= cfgWrData;
    end
  end

  // spin-up timer
  assign spinTicks     = SPIN_W'(TICK_BASE) << timeCode;
  assign kickTicks     = spinTicks >> 2;
  assign stat.spinLast = (spinCnt == spinTicks - SPIN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            spinCnt <= '0;
    else if (cmd.clrSpin) spinCnt <= '0;
    else if (cmd.incSpin) spinCnt <= spinCnt + SPIN_W'(1);
  end

  // drive-fail window
  always_comb begin
    winLen = '0;
    if (failCode != 2'b00) winLen = WIN_W'(WIN_BASE) << (failCode - 2'd1);
  end

  assign winLast = (winCnt == winLen - WIN_W'(1));
  assign failSet = winArmed && cmd.stepWin && !tachAtTarget && winLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winArmed <= 1'b0;
      winCnt   <= '0;
    end else if (cmd.dropWin) begin
      winArmed <= 1'b0;
    end else if (cmd.armWin) begin
      winArmed <= (failCode != 2'b00);
      winCnt   <= '0;
    end else if (winArmed && cmd.phase == PH_MON) begin
      if (tachAtTarget)   winArmed <= 1'b0;
      else if (cmd.stepWin) begin
        if (winLast) winArmed <= 1'b0;
        else         winCnt   <= winCnt + WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          driveFail <= 1'b0;
    else if (failSet)   driveFail <= 1'b1;
    else if (failClear) driveFail <= 1'b0;
  end

  // duty selection
  always_comb begin
    unique case (cmd.phase)
      PH_SPIN: dutyOut = (!noKick && spinCnt < kickTicks) ? DUTY_W'(FULL) : levelTab[spinLvl];
      PH_MON:  dutyOut = loopDuty;
      default: dutyOut = '0;
    endcase
  end

  assign cfgOut = cfgReg;
endmodule

// File: rtl/fan_start_seq.sv
module fan_start_seq
  import fss_pkg::*;
#(
  parameter int TICK_BASE = 250,
  parameter int WIN_BASE  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       lockSet,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       msTick,
  input  logic       updateStrobe,
  input  logic       tachAtTarget,
  input  logic [7:0] loopDuty,
  input  logic       failClear,
  output logic [7:0] dutyOut,
  output logic       spinActive,
  output logic       monitorActive,
  output logic       driveFail,
  output logic [7:0] cfgOut
);
  seq_cmd_t  cmd;
  seq_stat_t stat;

  fss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .msTick(msTick), .updateStrobe(updateStrobe), .stat(stat), .cmd(cmd)
  );

  fss_datapath #(.TICK_BASE(TICK_BASE), .WIN_BASE(WIN_BASE), .DUTY_W(8)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .lockSet(lockSet), .tachAtTarget(tachAtTarget), .loopDuty(loopDuty),
    .failClear(failClear), .stat(stat), .dutyOut(dutyOut),
    .driveFail(driveFail), .cfgOut(cfgOut)
  );

  assign spinActive    = (cmd.phase == PH_SPIN);
  assign monitorActive = (cmd.phase == PH_MON);
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
  input logic       clk,
  input logic       rstN,
  input logic       lockSet,
  input logic       startReq,
  input logic       stopReq,
  input logic       tachAtTarget,
  input logic       failClear,
  input logic [7:0] dutyOut,
  input logic       spinActive,
  input logic       monitorActive,
  input logic       driveFail,
  input logic [7:0] cfgOut
);
  logic lockSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lockSeen <= 1'b0;
    else if (lockSet) lockSeen <= 1'b1;
  end

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    lockSeen |=> $stable(cfgOut));

  assert_kick_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(spinActive) && !cfgOut[5]) |-> dutyOut == 8'hFF);

  assert_start_enters_spin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !stopReq) |=> spinActive);

  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!spinActive && !monitorActive && dutyOut == 8'h00));

  assert_phases_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spinActive, monitorActive}));

  assert_fail_needs_low_tach_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveFail) |-> ($past(monitorActive) && !$past(tachAtTarget)));

  assert_clear_outside_loop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (failClear && !monitorActive) |=> !driveFail);
endmodule

bind fan_start_seq fss_checker uChk (
  .clk(clk), .rstN(rstN), .lockSet(lockSet), .startReq(startReq), .stopReq(stopReq),
  .tachAtTarget(tachAtTarget), .failClear(failClear), .dutyOut(dutyOut),
  .spinActive(spinActive), .monitorActive(monitorActive), .driveFail(driveFail),
  .cfgOut(cfgOut)
);

// File: tb/fan_start_seq_test.sv
module fan_start_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       lockSet = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic       msTick = 1'b1;
  logic       updateStrobe = 1'b0;
  logic       tachAtTarget = 1'b0;
  logic [7:0] loopDuty = 8'h5A;
  logic       failClear = 1'b0;
  logic [7:0] dutyOut;
  logic       spinActive, monitorActive, driveFail;
  logic [7:0] cfgOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fan_start_seq uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .lockSet(lockSet), .startReq(startReq), .stopReq(stopReq), .msTick(msTick),
    .updateStrobe(updateStrobe), .tachAtTarget(tachAtTarget), .loopDuty(loopDuty),
    .failClear(failClear), .dutyOut(dutyOut), .spinActive(spinActive),
    .monitorActive(monitorActive), .driveFail(driveFail), .cfgOut(cfgOut)
  );

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int lvlDuty(int l);
    return ((30 + 5 * l) * 255) / 100;
  endfunction

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic startSpin();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic stopAll();
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
  endtask

  task automatic pulseUpd(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); updateStrobe = 1'b1;
      @(negedge clk); updateStrobe = 1'b0;
    end
  endtask

  task automatic testReset();
    chk("R1 cfg", cfgOut, 8'h0D);
    chk("R1 duty", dutyOut, 0);
    chk("R1 phase", {spinActive, monitorActive}, 0);
    chk("R1 fail", driveFail, 0);
  endtask

  task automatic testKick();
    writeCfg(8'b00_0_101_00);
    chk("R2 write", cfgOut, 8'b00_0_101_00);
    startSpin();
    chk("R4 kick start", dutyOut, 255);
    waitN(61);  chk("R4 kick end", dutyOut, 255);
    waitN(1);   chk("R6 level5", dutyOut, lvlDuty(5));
    waitN(187); chk("R7 250 spin", spinActive, 1);
    waitN(1);   chk("R7 250 mon", monitorActive, 1);
    chk("R7 loop duty", dutyOut, 8'h5A);
    stopAll();
  endtask

  task automatic testNoKick();
    writeCfg(8'b00_1_000_01);
    startSpin();
    chk("R5 no kick", dutyOut, lvlDuty(0));
    waitN(499); chk("R5 level held", dutyOut, lvlDuty(0));
    chk("R7 500 spin", spinActive, 1);
    waitN(1);   chk("R7 500 mon", monitorActive, 1);
    stopAll();
    writeCfg(8'b00_1_010_10);
    startSpin();
    chk("R6 level2", dutyOut, lvlDuty(2));
    waitN(999); chk("R7 1000 spin", spinActive, 1);
    waitN(1);   chk("R7 1000 mon", monitorActive, 1);
    stopAll();
    writeCfg(8'b00_0_111_11);
    startSpin();
    waitN(499); chk("R4 long kick", dutyOut, 255);
    waitN(1);   chk("R6 level7", dutyOut, lvlDuty(7));
    waitN(1499); chk("R7 2000 spin", spinActive, 1);
    waitN(1);   chk("R7 2000 mon", monitorActive, 1);
    stopAll();
  endtask

  task automatic testRestartStop();
    writeCfg(8'b00_0_011_00);
    startSpin();
    waitN(100); chk("R6 level3", dutyOut, lvlDuty(3));
    startSpin();
    chk("R8 kick again", dutyOut, 255);
    waitN(249); chk("R8 window restarted", spinActive, 1);
    waitN(1);   chk("R8 mon after restart", monitorActive, 1);
    startSpin();
    chk("R8 restart from loop", {spinActive, dutyOut}, {1'b1, 8'hFF});
    stopAll();
    chk("R9 stop idle", {spinActive, monitorActive, dutyOut}, 0);
    @(negedge clk); stopReq = 1'b1; startReq = 1'b1;
    @(negedge clk); stopReq = 1'b0; startReq = 1'b0;
    chk("R9 stop wins", {spinActive, monitorActive}, 0);
  endtask

  task automatic runFail(logic [1:0] code, int win);
    tachAtTarget = 1'b0;
    writeCfg({code, 6'b1_000_00});
    startSpin();
    waitN(250);
    chk("R10 in loop", monitorActive, 1);
    pulseUpd(win - 1);
    chk("R10 before window end", driveFail, 0);
    pulseUpd(1);
    chk("R10 window end", driveFail, 1);
    stopAll();
    chk("R12 sticky", driveFail, 1);
    @(negedge clk); failClear = 1'b1;
    @(negedge clk); failClear = 1'b0;
    chk("R12 clear", driveFail, 0);
  endtask

  task automatic testFailMisc();
    // tach reaching target ends the window
    writeCfg(8'b01_1_000_00);
    startSpin(); waitN(250);
    pulseUpd(10);
    @(negedge clk); tachAtTarget = 1'b1;
    @(negedge clk); tachAtTarget = 1'b0;
    pulseUpd(30);
    chk("R11 no fail", driveFail, 0);
    stopAll();
    // disabled window
    writeCfg(8'b00_1_000_00);
    startSpin(); waitN(250);
    pulseUpd(70);
    chk("R13 disabled", driveFail, 0);
    stopAll();
    // set wins over clear
    writeCfg(8'b01_1_000_00);
    startSpin(); waitN(250);
    pulseUpd(15);
    @(negedge clk); updateStrobe = 1'b1; failClear = 1'b1;
    @(negedge clk); updateStrobe = 1'b0; failClear = 1'b0;
    chk("R12 set wins", driveFail, 1);
    pulseUpd(20);
    @(negedge clk); failClear = 1'b1;
    @(negedge clk); failClear = 1'b0;
    pulseUpd(20);
    chk("R10 one shot", driveFail, 0);
    stopAll();
  endtask

  task automatic testLock();
    writeCfg(8'h55);
    chk("R2 readback", cfgOut, 8'h55);
    @(negedge clk); lockSet = 1'b1;
    @(negedge clk); lockSet = 1'b0;
    writeCfg(8'hAA);
    chk("R3 locked", cfgOut, 8'h55);
    waitN(5);
    writeCfg(8'h00);
    chk("R3 still locked", cfgOut, 8'h55);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        finishRun();
      end
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    testReset();
    testKick();
    testNoKick();
    testRestartStop();
    runFail(2'b01, 16);
    runFail(2'b10, 32);
    runFail(2'b11, 64);
    testFailMisc();
    testLock();
    finishRun();
  end
endmodule